// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block sits behind an instruction byte stream and works out where an instruction's operand lives. It takes an opcode byte and then the bytes that trail it, one per handshake, and classifies the instruction as inherent, immediate, direct or extended. It also counts how many operand bytes belong to the instruction. Then it either hands back the immediate value or forms a 16-bit effective address over a byte-wide memory. Direct addressing carries a single address byte, so it only reaches the bottom page. Extended addressing carries a full two-byte address, high byte first.

For the two memory modes the resolver makes one read on a synchronous memory port and returns the fetched byte. For the other two modes it finishes without touching memory. In every case a one-cycle done pulse marks the result. The decode table is small: load-A immediate ($86), load-A direct ($96), load-A extended ($B6) and the two-byte add-B-to-A ($18 $06). Every other byte pattern is reported as illegal. Any resolved address inside the low register window is flagged.

Top module: `opnd_resolver`

## Requirements
- R1: After reset, in_ready is 1 and done and mem_req are 0.
- R2: A byte is taken only in a cycle where in_valid and in_ready are both 1. From the cycle mem_req rises until the done cycle, in_ready stays 0.
- R3: Opcode $86 takes one trailing byte. In the cycle after that byte is taken, done is 1, mode is 1 (immediate), nbytes is 1 and imm_val equals the byte. No memory read takes place.
- R4: The pair $18 $06 is inherent. In the cycle after $06 is taken, done is 1, mode is 0, nbytes is 0 and no memory read takes place.
- R5: Opcode $96 takes one address byte. In the cycle after it is taken, mem_req is 1 and mem_addr is {$00, byte}. At done, mode is 2 and nbytes is 1.
- R6: Opcode $B6 takes a high byte and then a low byte. In the cycle after the low byte, mem_req is 1 and mem_addr is {high, low}. At done, mode is 3 and nbytes is 2.
- R7: mem_req lasts exactly one cycle. mem_rdata is taken in the next cycle, and done follows two cycles after the mem_req cycle, with operand equal to the byte read.
- R8: A first byte outside {$86,$96,$B6,$18}, or $18 followed by anything other than $06, gives done with illegal=1, mode 0 and nbytes 0 in the cycle after that byte is taken. No read takes place. Legal results give illegal=0.
- R9: reg_space is 1 with mem_req and at done when the effective address is at most $03FF. It is 0 for higher addresses and for immediate, inherent and illegal results.
- R10: in_ready is 1 in the done cycle, so the next opcode can be taken in the same cycle as done.
- R11: Idle cycles (in_valid low) between the bytes of one instruction do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Resolver can take a byte |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_req |
| done | output | 1 | One-cycle result pulse |
| mode | output | 2 | 0 inherent, 1 immediate, 2 direct, 3 extended |
| nbytes | output | 2 | Operand bytes consumed |
| imm_val | output | 8 | Immediate operand |
| eff_addr | output | 16 | Resolved effective address |
| operand | output | 8 | Byte fetched from memory |
| illegal | output | 1 | Opcode not in the table |
| reg_space | output | 1 | Effective address lies in the register window |

## Verification
The done pulse of one instruction and the taking of the next instruction's opcode can land in the same cycle. The bench provokes this by offering bytes back to back with no idle gaps, and by placing illegal and immediate instructions right after memory reads. A behavioural reference model, built on a byte queue, tracks the expected in_ready, mem_req and done cycle by cycle. A second overlap is the read strobe with the register-window flag. It is judged at both edges of the $03FF/$0400 boundary and on the lowest direct addresses.

// File: rtl/opr_pkg.sv
package opr_pkg;
    typedef enum logic [1:0] {
        AM_INH = 2'd0,
        AM_IMM = 2'd1,
        AM_DIR = 2'd2,
        AM_EXT = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        K_INH,
        K_IMM,
        K_DIR,
        K_EXT,
        K_PFX,
        K_BAD
    } okind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PFX,
        S_OPND,
        S_RD,
        S_WT
    } fsm_e;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [7:0]  OP_IMM = 8'h86,
    parameter logic [7:0]  OP_DIR = 8'h96,
    parameter logic [7:0]  OP_EXT = 8'hB6,
    parameter logic [7:0]  OP_PFX = 8'h18,
    parameter logic [7:0]  OP_INH = 8'h06
) (
    input  logic [DW-1:0] code,
    input  logic          second,
    output okind_e        kind
);
    always_comb begin
        kind = K_BAD;
        if (second) begin
            if (code == DW'(OP_INH)) kind = K_INH;
        end else begin
            if (code == DW'(OP_IMM)) kind = K_IMM;
            else if (code == DW'(OP_DIR)) kind = K_DIR;
            else if (code == DW'(OP_EXT)) kind = K_EXT;
            else if (code == DW'(OP_PFX)) kind = K_PFX;
        end
    end
endmodule

// File: rtl/opr_regspace.sv
module opr_regspace #(
    parameter int            AW  = 16,
    parameter logic [AW-1:0] TOP = 16'h03FF
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    assign hit = (addr <= TOP);
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opr_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            AW      = 2 * DW,
    parameter logic [AW-1:0] REG_TOP = 16'h03FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          in_ready,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [1:0]    mode,
    output logic [1:0]    nbytes,
    output logic [DW-1:0] imm_val,
    output logic [AW-1:0] eff_addr,
    output logic [DW-1:0] operand,
    output logic          illegal,
    output logic          reg_space
);
    localparam int HI_W = AW - DW;

    typedef struct packed {
        fsm_e          st;
        amode_e        pk;
        logic [1:0]    need;
        logic [1:0]    got;
        logic [AW-1:0] eff;
        logic          done;
        amode_e        mode;
        logic [1:0]    nb;
        logic [DW-1:0] imm;
        logic [DW-1:0] opnd;
        logic          ill;
        logic          rs;
    } rsv_t;

    rsv_t          r_q, r_d;
    okind_e        kind;
    logic [AW-1:0] addr_new;
    logic          hit;
    logic          acc;

    opr_decode #(.DW(DW)) u_dec (
        .code   (in_byte),
        .second (r_q.st == S_PFX),
        .kind   (kind)
    );

    always_comb begin
        if (r_q.pk == AM_DIR) addr_new = {{HI_W{1'b0}}, in_byte};
        else                  addr_new = {r_q.eff[DW-1:0], in_byte};
    end

    opr_regspace #(.AW(AW), .TOP(REG_TOP)) u_rs (
        .addr (addr_new),
        .hit  (hit)
    );

    assign in_ready = (r_q.st == S_IDLE) || (r_q.st == S_PFX) || (r_q.st == S_OPND);
    assign acc      = in_valid && in_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (acc) begin
                r_d.got = 2'd0;
                unique case (kind)
                    K_IMM: begin r_d.st = S_OPND; r_d.pk = AM_IMM; r_d.need = 2'd1; end
                    K_DIR: begin r_d.st = S_OPND; r_d.pk = AM_DIR; r_d.need = 2'd1; end
                    K_EXT: begin r_d.st = S_OPND; r_d.pk = AM_EXT; r_d.need = 2'd2; end
                    K_PFX: r_d.st = S_PFX;
                    default: begin
                        r_d.done = 1'b1; r_d.ill = 1'b1; r_d.mode = AM_INH;
                        r_d.nb = 2'd0; r_d.rs = 1'b0; r_d.st = S_IDLE;
                    end
                endcase
            end
            S_PFX: if (acc) begin
                r_d.done = 1'b1;
                r_d.mode = AM_INH;
                r_d.nb   = 2'd0;
                r_d.rs   = 1'b0;
                r_d.ill  = (kind != K_INH);
                r_d.st   = S_IDLE;
            end
            S_OPND: if (acc) begin
                r_d.eff = addr_new;
                r_d.got = r_q.got + 2'd1;
                if (r_q.got + 2'd1 == r_q.need) begin
                    r_d.ill  = 1'b0;
                    r_d.mode = r_q.pk;
                    r_d.nb   = r_q.need;
                    if (r_q.pk == AM_IMM) begin
                        r_d.done = 1'b1;
                        r_d.imm  = in_byte;
                        r_d.rs   = 1'b0;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.rs = hit;
                        r_d.st = S_RD;
                    end
                end
            end
            S_RD: r_d.st = S_WT;
            S_WT: begin
                r_d.opnd = mem_rdata;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, pk: AM_INH, mode: AM_INH, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.st == S_RD);
    assign mem_addr  = r_q.eff;
    assign done      = r_q.done;
    assign mode      = r_q.mode;
    assign nbytes    = r_q.nb;
    assign imm_val   = r_q.imm;
    assign eff_addr  = r_q.eff;
    assign operand   = r_q.opnd;
    assign illegal   = r_q.ill;
    assign reg_space = r_q.rs;

    // R2: no byte is taken while a read is outstanding
    p_ready_low_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready);

    // R7: one-cycle strobe, done two cycles later
    p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_read_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ##2 done);

    // R5: direct reads stay in the bottom page
    p_direct_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode == AM_DIR) |-> (mem_addr[AW-1:DW] == '0));

    // R9: register-window flag agrees with the address put on the port
    p_regspace_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (reg_space == (mem_addr <= REG_TOP)));

    // R3 and R4: short modes never went through a read
    p_no_read_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode == AM_IMM || mode == AM_INH)) |-> !$past(mem_req, 2));

    // R10: the resolver is open for the next opcode when it reports
    p_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);
endmodule

// File: tb/sim_opnd_resolver.sv
module sim_opnd_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        done;
    logic [1:0]  mode;
    logic [1:0]  nbytes;
    logic [7:0]  imm_val;
    logic [15:0] eff_addr;
    logic [7:0]  operand;
    logic        illegal;
    logic        reg_space;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit run = 1'b0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    opnd_resolver u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .mode(mode), .nbytes(nbytes),
        .imm_val(imm_val), .eff_addr(eff_addr), .operand(operand),
        .illegal(illegal), .reg_space(reg_space)
    );

    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

    // behavioural reference model
    logic [7:0]  q[$];
    int          phase;
    bit          e_ready, e_req, e_done, e_ill, e_rs;
    int          e_mode, e_nb;
    logic [7:0]  e_imm, e_opnd;
    logic [15:0] e_addr;

    task automatic bad_end(ref bit nd);
        nd = 1; e_mode = 0; e_nb = 0; e_ill = 1; e_rs = 0; q.delete();
    endtask

    task automatic start_rd(logic [15:0] a, int m, int n);
        e_req = 1; e_addr = a; e_ready = 0; phase = 1;
        e_mode = m; e_nb = n; e_ill = 0; e_rs = (a <= 16'h03FF); q.delete();
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete(); phase = 0; e_ready = 1; e_req = 0; e_done = 0;
            e_ill = 0; e_rs = 0; e_mode = 0; e_nb = 0; e_addr = 0;
        end else begin
            bit nd;
            nd = 0;
            if (phase == 1) begin
                phase = 2; e_req = 0;
            end else if (phase == 2) begin
                phase = 0; nd = 1; e_opnd = memf(e_addr); e_ready = 1;
            end else if (in_valid && e_ready) begin
                q.push_back(in_byte);
                case (q[0])
                    8'h86: if (q.size() == 2) begin
                        nd = 1; e_mode = 1; e_nb = 1; e_imm = q[1];
                        e_ill = 0; e_rs = 0; q.delete();
                    end
                    8'h96: if (q.size() == 2) start_rd({8'h00, q[1]}, 2, 1);
                    8'hB6: if (q.size() == 3) start_rd({q[1], q[2]}, 3, 2);
                    8'h18: if (q.size() == 2) begin
                        if (q[1] == 8'h06) begin
                            nd = 1; e_mode = 0; e_nb = 0; e_ill = 0; e_rs = 0; q.delete();
                        end else bad_end(nd);
                    end
                    default: bad_end(nd);
                endcase
            end
            e_done = nd;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run) begin
            chk("R2", "in_ready", int'(in_ready), int'(e_ready));
            chk("R7", "mem_req", int'(mem_req), int'(e_req));
            chk("R10", "done", int'(done), int'(e_done));
            if (e_req) begin
                chk(e_mode == 2 ? "R5" : "R6", "mem_addr", int'(mem_addr), int'(e_addr));
                chk("R9", "reg_space@req", int'(reg_space), int'(e_rs));
            end
            if (e_done && done) begin
                chk("R8", "illegal", int'(illegal), int'(e_ill));
                chk(e_mode == 3 ? "R6" : "R5", "mode", int'(mode), e_mode);
                chk("R11", "nbytes", int'(nbytes), e_nb);
                chk("R9", "reg_space@done", int'(reg_space), int'(e_rs));
                if (!e_ill && e_mode == 1) chk("R3", "imm_val", int'(imm_val), int'(e_imm));
                if (!e_ill && e_mode >= 2) chk("R7", "operand", int'(operand), int'(e_opnd));
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic send(logic [7:0] b, int gap = 0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); in_valid = 1'b0; in_byte = 8'hEE;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "done", int'(done), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        run = 1'b1;
        // R2: offered but invalid bytes are ignored
        idle(3);
        // R3: immediate
        send(8'h86); send(8'h3C); idle(2);
        // R4: inherent pair
        send(8'h18); send(8'h06); idle(2);
        // R5: direct, bottom page, R9 inside window
        send(8'h96); send(8'h42); idle(4);
        send(8'h96); send(8'hFF); idle(4);
        // R6: extended, R9 window edges
        send(8'hB6); send(8'h12); send(8'h34); idle(4);
        send(8'hB6); send(8'h03); send(8'hFF); idle(4);
        send(8'hB6); send(8'h04); send(8'h00); idle(4);
        send(8'hB6); send(8'h00); send(8'h00); idle(4);
        // R8: illegal patterns
        send(8'h55); idle(2);
        send(8'h18); send(8'h07); idle(2);
        send(8'h18); send(8'h18); idle(2);
        send(8'h06); idle(2);
        // R10: back to back, done with next opcode taken
        send(8'h86); send(8'h11); send(8'h18); send(8'h06);
        send(8'h77); send(8'h86); send(8'h01);
        send(8'hB6); send(8'h02); send(8'h80); send(8'h86); send(8'h5A);
        // R11: idle gaps inside an instruction
        send(8'hB6, 2); send(8'hAB, 3); send(8'hCD, 2); idle(4);
        send(8'h18, 1); send(8'h06, 4); idle(2);
        // mixed traffic
        for (int i = 0; i < 80; i++) begin
            int k = $urandom_range(0, 5);
            int g = $urandom_range(0, 2);
            logic [7:0] x = 8'($urandom);
            logic [7:0] y = 8'($urandom);
            case (k)
                0: begin send(8'h86, g); send(x, g); end
                1: begin send(8'h96, g); send(x, g); end
                2: begin send(8'hB6, g); send(y & 8'h07, g); send(x, g); end
                3: begin send(8'h18, g); send(8'h06, g); end
                4: begin send(8'h18, g); send(x | 8'h40, g); end
                default: send(8'hC1, g);
            endcase
        end
        idle(6);
        run = 1'b0;
        finish_run();
    end
endmodule